// File: doc/BRIEF.md
# Receive Data Register Loader

This block sits behind the receive side of a two-segment serial frame engine. Each frame has a first segment of N1 bytes and a second segment of N2 bytes. When a frame ends, the captured bytes wait in an external byte FIFO. On a start pulse the loader checks that the FIFO holds exactly N1 + N2 bytes. It then pops bytes one per clock and shifts the wanted ones into a 64-bit receive data register.

Two enables choose which segments reach the register:

- Only the first segment is wanted: its bytes are loaded and the second segment is left in the FIFO.
- Only the second segment is wanted: the first segment's bytes are popped and thrown away before the second segment is loaded.
- Both are wanted: the first segment is loaded, then the second.

At the end of a frame the loader flushes the FIFO and updates two status flags, full and overrun. A host read strobe marks the register as consumed. A masked 16-bit compare of the register's low half drives a match output that a sequencer can branch on.

Top module: `rdr_loader`

## Requirements
- R1: If `rxq_level` differs from `n1_bytes + n2_bytes` when a start is accepted, the loader pops nothing. It raises `len_err` together with `frame_done` in the first cycle after the start. The register and both flags stay unchanged.
- R2: Each loaded byte moves the register up by 8 bit positions and places the new byte in bits 7:0. Bits 63:56 are lost. The register changes only in cycles where a byte is popped.
- R3: When `n1_rx_en` is 1, FIFO bytes 0 to N1-1 are loaded in FIFO order.
- R4: With `n2_rx_en` 1 and `n1_rx_en` 0, the first N1 bytes are popped and discarded, and then the N2 bytes are loaded. With both enables 1, all N1 + N2 bytes are loaded. With `n2_rx_en` 0, the second segment is not popped.
- R5: At the end of a frame that loaded at least one byte: if `rdr_full` was already 1, `rdr_overrun` becomes 1 and stays 1 until reset; otherwise `rdr_full` becomes 1. A frame that loads nothing leaves both flags unchanged.
- R6: A `host_rd` pulse clears `rdr_full` on the next edge. If a frame sets the flag on the same edge, the flag is set.
- R7: `rdr_match` is 1 exactly when `(rdr_value[15:0] ^ match_value) & match_mask` is zero.
- R8: After an accepted start, one byte is popped in each of the next T cycles. T is N1 + N2 when `n2_rx_en` is 1, N1 when only `n1_rx_en` is 1, and 0 otherwise. `frame_done` and `rxq_flush` are high for the single cycle that follows the last pop, or the cycle after the start when T is 0.
- R9: The counts and enables are captured when a start is accepted. A start seen while a frame is in progress is ignored.
- R10: After reset, `rdr_value` is zero, both flags are 0, and no pop, done, flush or error is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Begin processing the captured frame |
| n1_bytes | input | CNT_W | Byte count of the first segment |
| n2_bytes | input | CNT_W | Byte count of the second segment |
| n1_rx_en | input | 1 | Load the first segment into the register |
| n2_rx_en | input | 1 | Load the second segment into the register |
| rxq_level | input | CNT_W+1 | Bytes currently held in the receive FIFO |
| rxq_data | input | BYTE_W | Head byte of the receive FIFO (show-ahead) |
| rxq_pop | output | 1 | Remove the head byte of the FIFO |
| rxq_flush | output | 1 | Empty the FIFO |
| host_rd | input | 1 | Host has read the register |
| match_mask | input | MATCH_W | Bits taking part in the compare |
| match_value | input | MATCH_W | Value compared against the register's low half |
| rdr_value | output | DATA_W | Receive data register |
| rdr_full | output | 1 | Register holds unread data |
| rdr_overrun | output | 1 | A frame landed while the register was unread |
| len_err | output | 1 | FIFO level did not match the frame length |
| frame_done | output | 1 | Frame processing finished |
| rdr_match | output | 1 | Masked compare result |

## Verification
Faults inside the block show up quickly at the ports:

- A wrong segment decision or byte index shows as a pop count that differs from T, or as a wrong register value, in the cycle after `frame_done`.
- A stale or wrongly latched count shows as `frame_done` arriving earlier or later than T + 1 cycles after the start.
- A wrong flag update shows one edge after `frame_done`, as `rdr_full` or `rdr_overrun` disagreeing with the prior state and the loaded-byte count.

The sweep covers every combination of segment lengths 0 to 3 and the four enable settings, so both the discard path and the no-load path are exercised.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_FIN   = 2'd2,
      ST_ABORT = 2'd3
   } rdr_state_e;
endpackage

// File: rtl/rdr_seq.sv
module rdr_seq
   import rdr_pkg::*;
#(
   parameter int CNT_W = 4,
   localparam int LVL_W = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] n1_bytes,
   input  logic [CNT_W-1:0] n2_bytes,
   input  logic             n1_rx_en,
   input  logic             n2_rx_en,
   input  logic [LVL_W-1:0] level,
   output logic             pop,
   output logic             load,
   output logic             done,
   output logic             flush,
   output logic             len_err,
   output logic             frame_set
);
   rdr_state_e       state;
   logic [LVL_W-1:0] idx;
   logic [LVL_W-1:0] total;
   logic [CNT_W-1:0] n1_q;
   logic             n1_rx_q;
   logic             n2_rx_q;
   logic             any_q;
   logic [LVL_W-1:0] sum_d;
   logic [LVL_W-1:0] total_d;
   logic             in_seg1;

   always_comb begin
      sum_d = {1'b0, n1_bytes} + {1'b0, n2_bytes};
      if (n2_rx_en)
         total_d = sum_d;
      else if (n1_rx_en)
         total_d = {1'b0, n1_bytes};
      else
         total_d = '0;
   end

   assign in_seg1   = (idx < {1'b0, n1_q});
   assign pop       = (state == ST_RUN);
   assign load      = pop && (in_seg1 ? n1_rx_q : n2_rx_q);
   assign done      = (state == ST_FIN) || (state == ST_ABORT);
   assign flush     = done;
   assign len_err   = (state == ST_ABORT);
   assign frame_set = (state == ST_FIN) && any_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         idx     <= '0;
         total   <= '0;
         n1_q    <= '0;
         n1_rx_q <= 1'b0;
         n2_rx_q <= 1'b0;
         any_q   <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  idx     <= '0;
                  any_q   <= 1'b0;
                  n1_q    <= n1_bytes;
                  n1_rx_q <= n1_rx_en;
                  n2_rx_q <= n2_rx_en;
                  total   <= total_d;
                  if (level != sum_d)
                     state <= ST_ABORT;
                  else if (total_d == '0)
                     state <= ST_FIN;
                  else
                     state <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (load)
                  any_q <= 1'b1;
               idx <= idx + 1'b1;
               if (idx == total - 1'b1)
                  state <= ST_FIN;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rdr_shift.sv
module rdr_shift #(
   parameter int DATA_W = 64,
   parameter int BYTE_W = 8,
   localparam int LANES = DATA_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] din,
   input  logic              frame_set,
   input  logic              host_rd,
   output logic [DATA_W-1:0] rdr,
   output logic              full,
   output logic              overrun
);
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            rdr[j*BYTE_W +: BYTE_W] <= '0;
         else if (load) begin
            if (j == 0)
               rdr[j*BYTE_W +: BYTE_W] <= din;
            else
               rdr[j*BYTE_W +: BYTE_W] <= rdr[(j-1)*BYTE_W +: BYTE_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full    <= 1'b0;
         overrun <= 1'b0;
      end else begin
         full    <= frame_set | (full & ~host_rd);
         overrun <= overrun | (frame_set & full);
      end
   end
endmodule

// File: rtl/rdr_match.sv
module rdr_match #(
   parameter int MATCH_W = 16,
   parameter bit PIPE    = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [MATCH_W-1:0] low,
   input  logic [MATCH_W-1:0] mask,
   input  logic [MATCH_W-1:0] value,
   output logic               hit
);
   logic [MATCH_W-1:0] bit_ok;

   for (genvar b = 0; b < MATCH_W; b++) begin : g_bit
      assign bit_ok[b] = ~mask[b] | (low[b] == value[b]);
   end

   if (PIPE) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            hit <= 1'b0;
         else
            hit <= &bit_ok;
      end
   end else begin : g_comb
      assign hit = &bit_ok;
   end
endmodule

// File: rtl/rdr_loader.sv
module rdr_loader #(
   parameter int DATA_W     = 64,
   parameter int BYTE_W     = 8,
   parameter int CNT_W      = 4,
   parameter int MATCH_W    = 16,
   parameter bit MATCH_PIPE = 1'b0,
   localparam int LVL_W     = CNT_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start,
   input  logic [CNT_W-1:0]   n1_bytes,
   input  logic [CNT_W-1:0]   n2_bytes,
   input  logic               n1_rx_en,
   input  logic               n2_rx_en,
   input  logic [LVL_W-1:0]   rxq_level,
   input  logic [BYTE_W-1:0]  rxq_data,
   output logic               rxq_pop,
   output logic               rxq_flush,
   input  logic               host_rd,
   input  logic [MATCH_W-1:0] match_mask,
   input  logic [MATCH_W-1:0] match_value,
   output logic [DATA_W-1:0]  rdr_value,
   output logic               rdr_full,
   output logic               rdr_overrun,
   output logic               len_err,
   output logic               frame_done,
   output logic               rdr_match
);
   if (DATA_W % BYTE_W != 0) begin : g_bad_lanes
      $error("DATA_W must be a whole number of bytes");
   end
   if (MATCH_W > DATA_W) begin : g_bad_match
      $error("MATCH_W must not exceed DATA_W");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic load;
   logic frame_set;

   rdr_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (frame_start),
      .n1_bytes  (n1_bytes),
      .n2_bytes  (n2_bytes),
      .n1_rx_en  (n1_rx_en),
      .n2_rx_en  (n2_rx_en),
      .level     (rxq_level),
      .pop       (rxq_pop),
      .load      (load),
      .done      (frame_done),
      .flush     (rxq_flush),
      .len_err   (len_err),
      .frame_set (frame_set)
   );

   rdr_shift #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .din       (rxq_data),
      .frame_set (frame_set),
      .host_rd   (host_rd),
      .rdr       (rdr_value),
      .full      (rdr_full),
      .overrun   (rdr_overrun)
   );

   rdr_match #(.MATCH_W(MATCH_W), .PIPE(MATCH_PIPE)) u_match (
      .clk   (clk),
      .rst_n (rst_n),
      .low   (rdr_value[MATCH_W-1:0]),
      .mask  (match_mask),
      .value (match_value),
      .hit   (rdr_match)
   );
endmodule

// File: rtl/rdr_loader_chk.sv
module rdr_loader_chk #(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W:0]    rxq_level,
   input logic              rxq_pop,
   input logic              rxq_flush,
   input logic              host_rd,
   input logic [DATA_W-1:0] rdr_value,
   input logic              rdr_full,
   input logic              rdr_overrun,
   input logic              len_err,
   input logic              frame_done
);
   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      len_err |-> (frame_done && !rxq_pop));                       // R1
   AST_RDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rxq_pop |=> $stable(rdr_value));                            // R2
   AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdr_overrun) |-> $past(rdr_full));                     // R5
   AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !frame_done) |=> !rdr_full);                     // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);                                 // R8
   AST_FLUSH_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rxq_flush |-> frame_done);                                   // R8
   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      rxq_pop |-> (rxq_level != '0));                              // R8
endmodule

bind rdr_loader rdr_loader_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rxq_level   (rxq_level),
   .rxq_pop     (rxq_pop),
   .rxq_flush   (rxq_flush),
   .host_rd     (host_rd),
   .rdr_value   (rdr_value),
   .rdr_full    (rdr_full),
   .rdr_overrun (rdr_overrun),
   .len_err     (len_err),
   .frame_done  (frame_done)
);

// File: tb/rdr_loader_test.sv
module rdr_loader_test;
   localparam int CNT_W = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic [3:0]  n1_bytes = '0;
   logic [3:0]  n2_bytes = '0;
   logic        n1_rx_en = 1'b0;
   logic        n2_rx_en = 1'b0;
   logic [4:0]  rxq_level = '0;
   logic [7:0]  rxq_data;
   logic        rxq_pop;
   logic        rxq_flush;
   logic        host_rd = 1'b0;
   logic [15:0] match_mask = '0;
   logic [15:0] match_value = '0;
   logic [63:0] rdr_value;
   logic        rdr_full;
   logic        rdr_overrun;
   logic        len_err;
   logic        frame_done;
   logic        rdr_match;

   logic [7:0]  mem [32];
   logic [4:0]  rp = '0;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   logic [63:0] exp_rdr = '0;
   logic        exp_full = 1'b0;
   logic        exp_ovr  = 1'b0;

   always #10 clk = ~clk;

   rdr_loader uut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .n1_bytes(n1_bytes), .n2_bytes(n2_bytes),
      .n1_rx_en(n1_rx_en), .n2_rx_en(n2_rx_en),
      .rxq_level(rxq_level), .rxq_data(rxq_data),
      .rxq_pop(rxq_pop), .rxq_flush(rxq_flush), .host_rd(host_rd),
      .match_mask(match_mask), .match_value(match_value),
      .rdr_value(rdr_value), .rdr_full(rdr_full), .rdr_overrun(rdr_overrun),
      .len_err(len_err), .frame_done(frame_done), .rdr_match(rdr_match)
   );

   assign rxq_data = mem[rp];

   always @(posedge clk) begin
      if (rxq_flush) begin
         rxq_level <= '0;
         rp        <= '0;
      end else if (rxq_pop) begin
         rxq_level <= rxq_level - 1'b1;
         rp        <= rp + 1'b1;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         bad   = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int k, input int i);
      return 8'(k * 37 + i * 11 + 5);
   endfunction

   task automatic host_read();
      @(negedge clk) host_rd = 1'b1;
      @(negedge clk) host_rd = 1'b0;
      exp_full = 1'b0;
   endtask

   // extra != 0 makes the FIFO level wrong (R1); restart asserts a second start mid-frame (R9)
   task automatic run_frame(input int k, input int n1, input int n2, input bit r1, input bit r2,
                            input int extra, input bit restart);
      int  t;
      int  pops;
      int  cycles;
      bit  any;
      @(negedge clk);
      for (int i = 0; i < 32; i++) mem[i] = pat(k, i);
      rp        = '0;
      rxq_level = 5'(n1 + n2 + extra);
      n1_bytes  = 4'(n1);
      n2_bytes  = 4'(n2);
      n1_rx_en  = r1;
      n2_rx_en  = r2;
      frame_start = 1'b1;
      t = (extra != 0) ? 0 : (r2 ? n1 + n2 : (r1 ? n1 : 0));
      any = 1'b0;
      if (extra == 0) begin
         for (int i = 0; i < n1 + n2; i++) begin
            if (i < n1 ? r1 : r2) begin
               exp_rdr = {exp_rdr[55:0], pat(k, i)};
               any = 1'b1;
            end
         end
      end
      pops = 0;
      cycles = 0;
      @(negedge clk) frame_start = 1'b0;
      cycles = 1;
      while (!frame_done && cycles < 100) begin
         if (rxq_pop) pops++;
         if (restart && cycles == 2) begin
            frame_start = 1'b1;
            n1_bytes = 4'd1;
            n1_rx_en = ~r1;
         end else begin
            frame_start = 1'b0;
         end
         @(negedge clk);
         cycles++;
      end
      frame_start = 1'b0;
      check("R8 done timing", 64'(cycles), 64'(t + 1));
      check((r1 && !r2) ? "R3 pop count" : "R4 pop count", 64'(pops), 64'(t));
      check("R1 len_err", 64'(len_err), 64'(extra != 0));
      check("R8 flush with done", 64'(rxq_flush), 64'd1);
      if (any) begin
         if (exp_full) exp_ovr = 1'b1;
         else exp_full = 1'b1;
      end
      @(negedge clk);
      check(r1 ? "R3 rdr" : "R4 rdr", rdr_value, exp_rdr);
      check("R5 full", 64'(rdr_full), 64'(exp_full));
      check("R5 overrun", 64'(rdr_overrun), 64'(exp_ovr));
      check("R8 done one cycle", 64'(frame_done), 64'd0);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      check("R10 rdr reset", rdr_value, 64'd0);
      check("R10 full reset", 64'(rdr_full), 64'd0);
      check("R10 overrun reset", 64'(rdr_overrun), 64'd0);
      check("R10 quiet", 64'({rxq_pop, frame_done, rxq_flush, len_err}), 64'd0);
      rst_n = 1'b1;

      // sweep lengths 0..3 and all enable settings (R2, R3, R4, R5, R8)
      for (int k = 0; k < 64; k++) begin
         if (k % 4 != 3) host_read();
         run_frame(k, k % 4, (k / 4) % 4, k[4], k[5], 0, 1'b0);
      end

      // fresh state for directed cases
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      exp_rdr = '0; exp_full = 1'b0; exp_ovr = 1'b0;
      check("R10 rdr after reset", rdr_value, 64'd0);

      run_frame(100, 2, 1, 1'b1, 1'b0, 0, 1'b0);   // R5 sets full
      run_frame(101, 1, 2, 1'b1, 1'b1, 0, 1'b0);   // R5 overrun, full unread
      run_frame(102, 2, 2, 1'b1, 1'b1, 1, 1'b0);   // R1 mismatch, nothing changes
      run_frame(103, 3, 3, 1'b0, 1'b1, 0, 1'b1);   // R9 mid-frame start ignored
      run_frame(104, 9, 3, 1'b1, 1'b1, 0, 1'b0);   // R2 more than 8 bytes, oldest lost

      host_read();
      @(negedge clk);
      check("R6 host read clears full", 64'(rdr_full), 64'd0);
      check("R6 overrun stays", 64'(rdr_overrun), 64'd1);

      // R7 masked compare sweep
      for (int j = 0; j < 64; j++) begin
         logic [15:0] m;
         logic [15:0] v;
         m = 16'(j * 16'h1357) ^ 16'(j << 9);
         v = rdr_value[15:0] ^ (j[0] ? 16'(j * 2731) : (~m & 16'(j * 2731)));
         @(negedge clk);
         match_mask  = m;
         match_value = v;
         #1;
         check("R7 match", 64'(rdr_match), 64'(((rdr_value[15:0] ^ v) & m) == 16'd0));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule